// File: doc/BRIEF.md
# Bus Link Loopback and Control Unit

This block is the control and diagnostic front end of a serial bus data-link controller. It holds the 8-bit control register, which carries the receive-mute flag, the clock-select bit, a write-once rate field and two plain enable bits. It also holds a small diagnostic register that selects two loopback modes. The downstream encoder, framer and clock divider take the rate and clock-select values from its outputs. The receiver takes a gated receive bit and a receive-enable from it. The transmitter waits on its transmit-permit.

The receive bit normally comes from the external transceiver. In digital loopback it comes from the controller's own transmit bit, while that transmit bit still goes out to the transceiver. Analog loopback leaves both data paths alone. When analog loopback is switched off, the block holds transmission back until it has seen the bus at its passive level for a set number of consecutive clock cycles. The receive-mute flag keeps the receiver off until the next start of frame is reported. Software can set the flag again at any time.

Top module: `buslink_ctrl`

## Requirements
- R1: After reset, the control register reads 8'hE0 (mute 1, clock-select 1, rate 2'b10, all other bits 0). The diagnostic register reads 8'h00, tx_permit is 1 and rx_enable is 0.
- R2: With digital loopback on (diagnostic bit 0 = 1) and the receiver enabled, rx_bit equals tx_bit. tx_out always equals tx_bit.
- R3: With digital loopback off and the receiver enabled, rx_bit equals bus_rx.
- R4: While the mute flag (control bit 7) is 1, rx_enable is 0 and rx_bit stays at the passive level (0).
- R5: A sof_det pulse with no control write in the same cycle clears the mute flag, so rx_enable is 1 from the next cycle.
- R6: A control write sets or clears the mute flag from data bit 7. When that write coincides with sof_det, the written value wins.
- R7: The rate field (control bits 5:4, output rate_sel) takes the value of the first control write after reset. Every later write leaves it unchanged.
- R8: Control bits 3:2 always read 0, whatever is written.
- R9: clk_sel follows control bit 6 (0 selects the 1 MHz integer base, 1 the 1.048576 MHz binary base). The bit can be rewritten at any time.
- R10: With analog loopback on (diagnostic bit 1 = 1), rx_bit still follows bus_rx and tx_out still follows tx_bit.
- R11: A diagnostic write that clears analog loopback drops tx_permit from the next cycle. tx_permit stays low until bus_rx has been passive for IDLE_CYCLES consecutive cycles after that write, and it rises one cycle later. With a passive bus this gives IDLE_CYCLES+1 low cycles.
- R12: An active bus_rx sample while the idle wait is pending restarts the count of passive cycles.
- R13: Turning analog loopback on, or any write that does not clear it, leaves tx_permit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 diagnostic |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the register selected by addr |
| sof_det | input | 1 | Start-of-frame detected pulse |
| bus_rx | input | 1 | Receive line from the external transceiver |
| tx_bit | input | 1 | Transmit bit from the encoder |
| tx_out | output | 1 | Transmit line to the external transceiver |
| rx_bit | output | 1 | Gated receive bit to the decoder |
| rx_enable | output | 1 | Receiver enabled (mute flag clear) |
| tx_permit | output | 1 | Transmission allowed |
| rate_sel | output | 2 | Rate-select field for the clock divider |
| clk_sel | output | 1 | Clock-select bit |
| irq_en | output | 1 | Interrupt-enable control bit |
| wait_ctl | output | 1 | Wait-mode control bit |

## Verification
The bench builds the block with IDLE_CYCLES = 4 and the passive level at 0. This keeps the whole idle wait after an analog-loopback exit to a handful of cycles, so the bench can count its full length and compare it with the expected IDLE_CYCLES+1 low cycles. The short window also lets an active pulse land inside the wait, which shows that the count restarts. The same setting leaves room for a run of control writes that covers the write-once rate lock, the mute flag colliding with a start of frame, and both loopback routes.

// File: rtl/blc_pkg.sv
package blc_pkg;
  localparam int CTL_MUTE   = 7;
  localparam int CTL_CLKSEL = 6;
  localparam int CTL_RATE_H = 5;
  localparam int CTL_RATE_L = 4;
  localparam int CTL_IRQEN  = 1;
  localparam int CTL_WAIT   = 0;
  localparam int DIAG_DLOOP = 0;
  localparam int DIAG_ALOOP = 1;
  localparam logic [1:0] RATE_RESET = 2'b10;

  typedef enum logic {
    SEL_CTL  = 1'b0,
    SEL_DIAG = 1'b1
  } blc_sel_e;

  typedef struct packed {
    logic       mute;
    logic       clksel;
    logic [1:0] rate;
    logic       irqen;
    logic       waitc;
  } blc_ctl_t;
endpackage

// File: rtl/blc_ctrl_reg.sv
module blc_ctrl_reg
  import blc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wr_data,
  input  logic       sof_det,
  output blc_ctl_t   ctl,
  output logic       dloop,
  output logic       aloop,
  output logic       aloop_exit,
  output logic [7:0] rd_data
);
  logic       wr_ctl, wr_diag;
  logic       mute_q, mute_d, mute_en;
  logic       clksel_q, irqen_q, waitc_q;
  logic [1:0] rate_q;
  logic       rate_done_q, rate_en;
  logic       dloop_q, aloop_q;

  assign wr_ctl  = wr_en && (addr == SEL_CTL);
  assign wr_diag = wr_en && (addr == SEL_DIAG);

  // Mute flag next state: a write takes priority over a start of frame
  always_comb begin
    mute_en = 1'b0;
    mute_d  = mute_q;
    if (wr_ctl) begin
      mute_en = 1'b1;
      mute_d  = wr_data[CTL_MUTE];
    end else if (sof_det) begin
      mute_en = 1'b1;
      mute_d  = 1'b0;
    end
  end

  assign rate_en = wr_ctl && !rate_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_q <= 1'b1;
    else if (mute_en) mute_q <= mute_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clksel_q <= 1'b1;
      irqen_q  <= 1'b0;
      waitc_q  <= 1'b0;
    end else if (wr_ctl) begin
      clksel_q <= wr_data[CTL_CLKSEL];
      irqen_q  <= wr_data[CTL_IRQEN];
      waitc_q  <= wr_data[CTL_WAIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q      <= RATE_RESET;
      rate_done_q <= 1'b0;
    end else if (rate_en) begin
      rate_q      <= wr_data[CTL_RATE_H:CTL_RATE_L];
      rate_done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dloop_q <= 1'b0;
      aloop_q <= 1'b0;
    end else if (wr_diag) begin
      dloop_q <= wr_data[DIAG_DLOOP];
      aloop_q <= wr_data[DIAG_ALOOP];
    end
  end

  assign aloop_exit = wr_diag && aloop_q && !wr_data[DIAG_ALOOP];

  assign ctl.mute   = mute_q;
  assign ctl.clksel = clksel_q;
  assign ctl.rate   = rate_q;
  assign ctl.irqen  = irqen_q;
  assign ctl.waitc  = waitc_q;
  assign dloop      = dloop_q;
  assign aloop      = aloop_q;

  always_comb begin
    if (addr == SEL_CTL)
      rd_data = {mute_q, clksel_q, rate_q, 2'b00, irqen_q, waitc_q};
    else
      rd_data = {6'b0, aloop_q, dloop_q};
  end

  // R7: once the first write has landed the rate field never moves
  a_r7_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
    rate_done_q |=> (rate_q == $past(rate_q)));
  // R8: the reserved bits of the control register never read as one
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == SEL_CTL) |-> (rd_data[3:2] == 2'b00));
endmodule

// File: rtl/blc_rx_path.sv
module blc_rx_path #(
  parameter logic PASSIVE_LVL = 1'b0
) (
  input  logic dloop,
  input  logic rx_en,
  input  logic bus_rx,
  input  logic tx_bit,
  output logic rx_bit,
  output logic tx_out
);
  logic rx_src;

  assign rx_src = dloop ? tx_bit : bus_rx;
  assign rx_bit = rx_en ? rx_src : PASSIVE_LVL;
  assign tx_out = tx_bit;
endmodule

// File: rtl/blc_idle_guard.sv
module blc_idle_guard #(
  parameter int   IDLE_CYCLES = 8,
  parameter logic PASSIVE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rx,
  input  logic aloop_exit,
  output logic tx_permit
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_CYCLES);

  logic [CW-1:0] run_q, run_d;
  logic          run_en;
  logic          pend_q, pend_d, pend_en;
  logic          bus_active, idle_met;

  assign bus_active = (bus_rx != PASSIVE_LVL);
  assign idle_met   = (run_q == CNT_MAX);

  // Count of consecutive passive samples, saturating at the threshold
  always_comb begin
    run_en = 1'b1;
    run_d  = run_q;
    if (aloop_exit || bus_active) run_d = '0;
    else if (!idle_met)           run_d = run_q + 1'b1;
    else                          run_en = 1'b0;
  end

  // Sticky pending-idle flag
  always_comb begin
    pend_en = 1'b0;
    pend_d  = pend_q;
    if (aloop_exit) begin
      pend_en = 1'b1;
      pend_d  = 1'b1;
    end else if (pend_q && idle_met) begin
      pend_en = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign tx_permit = !pend_q;

  // R11: leaving analog loopback blocks transmission on the next cycle
  a_r11_exit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    aloop_exit |=> !tx_permit);
  // R12: permission only returns after a passive sample in the counted window
  a_r12_idle_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> ($past(bus_rx, 2) == PASSIVE_LVL));
endmodule

// File: rtl/buslink_ctrl.sv
module buslink_ctrl
  import blc_pkg::*;
#(
  parameter int   IDLE_CYCLES = 8,
  parameter logic PASSIVE_LVL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sof_det,
  input  logic       bus_rx,
  input  logic       tx_bit,
  output logic       tx_out,
  output logic       rx_bit,
  output logic       rx_enable,
  output logic       tx_permit,
  output logic [1:0] rate_sel,
  output logic       clk_sel,
  output logic       irq_en,
  output logic       wait_ctl
);
  blc_ctl_t ctl;
  logic     dloop, aloop, aloop_exit;

  blc_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .sof_det   (sof_det),
    .ctl       (ctl),
    .dloop     (dloop),
    .aloop     (aloop),
    .aloop_exit(aloop_exit),
    .rd_data   (rd_data)
  );

  assign rx_enable = !ctl.mute;
  assign rate_sel  = ctl.rate;
  assign clk_sel   = ctl.clksel;
  assign irq_en    = ctl.irqen;
  assign wait_ctl  = ctl.waitc;

  blc_rx_path #(.PASSIVE_LVL(PASSIVE_LVL)) u_rx (
    .dloop (dloop),
    .rx_en (rx_enable),
    .bus_rx(bus_rx),
    .tx_bit(tx_bit),
    .rx_bit(rx_bit),
    .tx_out(tx_out)
  );

  blc_idle_guard #(.IDLE_CYCLES(IDLE_CYCLES), .PASSIVE_LVL(PASSIVE_LVL)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rx    (bus_rx),
    .aloop_exit(aloop_exit),
    .tx_permit (tx_permit)
  );

  // R2: in digital loopback the receiver sees the transmit bit
  a_r2_loop_source: assert property (@(posedge clk) disable iff (!rst_n)
    (dloop && rx_enable) |-> (rx_bit == tx_bit));
  // R4: a muted receiver outputs only the passive level
  a_r4_muted: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> (rx_bit == PASSIVE_LVL));
  // R5: a start of frame without a write re-enables reception
  a_r5_sof_unmutes: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_det && !(wr_en && addr == SEL_CTL)) |=> rx_enable);
  // R6: a write of one to the mute bit beats a coincident start of frame
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SEL_CTL && wr_data[CTL_MUTE] && sof_det) |=> !rx_enable);
  // R10: analog loopback leaves the receive source on the bus line
  a_r10_analog_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (aloop && !dloop && rx_enable) |-> (rx_bit == bus_rx));
endmodule

// File: tb/sim_buslink_ctrl.sv
`timescale 1ns/1ps
module sim_buslink_ctrl;
  localparam int N = 4;

  logic       clk;
  logic       rst_n;
  logic       wr_en, addr, sof_det, bus_rx, tx_bit;
  logic [7:0] wr_data, rd_data;
  logic       tx_out, rx_bit, rx_enable, tx_permit, clk_sel, irq_en, wait_ctl;
  logic [1:0] rate_sel;

  int errs;
  int checks;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  buslink_ctrl #(.IDLE_CYCLES(N), .PASSIVE_LVL(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .sof_det(sof_det), .bus_rx(bus_rx), .tx_bit(tx_bit),
    .tx_out(tx_out), .rx_bit(rx_bit), .rx_enable(rx_enable), .tx_permit(tx_permit),
    .rate_sel(rate_sel), .clk_sel(clk_sel), .irq_en(irq_en), .wait_ctl(wait_ctl)
  );

  // Behavioural reference state
  bit       m_mute, m_clk, m_done, m_ie, m_wt, m_dl, m_al, m_pend;
  bit [1:0] m_rate;
  int       m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mute = 1; m_clk = 1; m_rate = 2'b10; m_done = 0; m_ie = 0; m_wt = 0;
      m_dl = 0; m_al = 0; m_pend = 0; m_run = 0;
    end else begin
      bit ex;
      ex = wr_en && addr && m_al && !wr_data[1];
      if (wr_en && !addr) begin
        m_mute = wr_data[7]; m_clk = wr_data[6]; m_ie = wr_data[1]; m_wt = wr_data[0];
        if (!m_done) begin m_rate = wr_data[5:4]; m_done = 1; end
      end else if (sof_det) m_mute = 0;
      if (wr_en && addr) begin m_dl = wr_data[0]; m_al = wr_data[1]; end
      if (ex) m_pend = 1;
      else if (m_run == N) m_pend = 0;
      if (ex || bus_rx) m_run = 0;
      else if (m_run < N) m_run = m_run + 1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    logic src, erx;
    logic [7:0] erd;
    src = m_dl ? tx_bit : bus_rx;
    erx = m_mute ? 1'b0 : src;
    erd = addr ? {6'b0, m_al, m_dl} : {m_mute, m_clk, m_rate, 2'b00, m_ie, m_wt};
    chk("R4 rx_bit model", {7'b0, rx_bit}, {7'b0, erx});
    chk("R4 rx_enable model", {7'b0, rx_enable}, {7'b0, !m_mute});
    chk("R11 tx_permit model", {7'b0, tx_permit}, {7'b0, !m_pend});
    chk("R2 tx_out model", {7'b0, tx_out}, {7'b0, tx_bit});
    chk("R7 rate_sel model", {6'b0, rate_sel}, {6'b0, m_rate});
    chk("R9 clk_sel model", {7'b0, clk_sel}, {7'b0, m_clk});
    chk("R8 rd_data model", rd_data, erd);
  endtask

  task automatic step(input logic we, input logic a, input logic [7:0] d,
                      input logic sof, input logic bus, input logic txb);
    @(negedge clk);
    wr_en = we; addr = a; wr_data = d; sof_det = sof; bus_rx = bus; tx_bit = txb;
    #1 cmp_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int lows;
    errs = 0; checks = 0; done = 0;
    rst_n = 0; wr_en = 0; addr = 0; wr_data = 0; sof_det = 0; bus_rx = 0; tx_bit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 ctl reset", rd_data, 8'hE0);
    chk("R1 tx_permit reset", {7'b0, tx_permit}, 8'h01);
    chk("R1 rx_enable reset", {7'b0, rx_enable}, 8'h00);
    step(0, 1, 8'h00, 0, 0, 0);
    chk("R1 diag reset", rd_data, 8'h00);
    // R4 muted receiver ignores bus
    step(0, 0, 8'h00, 0, 1, 1);
    chk("R4 muted rx_bit", {7'b0, rx_bit}, 8'h00);
    // R5 start of frame unmutes
    step(0, 0, 8'h00, 1, 1, 0);
    step(0, 0, 8'h00, 0, 1, 0);
    chk("R5 unmuted after sof", {7'b0, rx_enable}, 8'h01);
    // R3 normal pass-through patterns
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 8'h00, 0, logic'(i % 2), logic'((i / 2) % 2));
      chk("R3 rx follows bus", {7'b0, rx_bit}, {7'b0, bus_rx});
    end
    // R7/R8/R9 first control write
    step(1, 0, 8'h3F, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0);
    chk("R8 reserved bits", rd_data & 8'h0C, 8'h00);
    chk("R7 first rate write", {6'b0, rate_sel}, 8'h03);
    chk("R9 clk_sel cleared", {7'b0, clk_sel}, 8'h00);
    // R7 second write ignored for the rate
    step(1, 0, 8'hE7, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0);
    chk("R7 rate locked", {6'b0, rate_sel}, 8'h03);
    chk("R9 clk_sel set", {7'b0, clk_sel}, 8'h01);
    chk("R6 mute written", {7'b0, rx_enable}, 8'h00);
    // R6 write beats coincident sof
    step(0, 0, 8'h00, 1, 0, 0);
    step(1, 0, 8'h80, 1, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0);
    chk("R6 write wins over sof", {7'b0, rx_enable}, 8'h00);
    // R2 digital loopback
    step(1, 1, 8'h01, 1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 8'h00, 0, logic'(i % 2 == 0), logic'(i % 2));
      chk("R2 loop rx equals tx", {7'b0, rx_bit}, {7'b0, tx_bit});
    end
    // R10/R13 analog loopback on
    step(1, 1, 8'h02, 0, 0, 0);
    chk("R13 permit kept on entry", {7'b0, tx_permit}, 8'h01);
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 8'h00, 0, logic'(i % 2), logic'(i < 2));
      chk("R10 rx follows bus in analog loop", {7'b0, rx_bit}, {7'b0, bus_rx});
      chk("R13 permit during analog loop", {7'b0, tx_permit}, 8'h01);
    end
    // R11 exit with passive bus
    step(1, 1, 8'h00, 0, 0, 0);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      step(0, 1, 8'h00, 0, 0, 1);
      if (!tx_permit) lows++;
    end
    chk("R11 idle wait length", 8'(lows), 8'(N + 1));
    // R12 active sample restarts count
    step(1, 1, 8'h02, 0, 0, 0);
    step(1, 1, 8'h00, 0, 0, 0);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      step(0, 1, 8'h00, 0, (i == 2), 0);
      if (!tx_permit) lows++;
    end
    chk("R12 restarted wait length", 8'(lows), 8'(N + 4));
    finish_run();
  end
endmodule